// File: doc/BRIEF.md
# Multi-Mode 8-bit Timer/Counter

This block is an 8-bit up counter with a choice of count sources and three ways of working. As an interval timer it counts up to a reference value, returns to zero, flips its output pin and raises a match flag. As a pulse-width modulator it runs freely through all 256 states and drives its output high while the reference is above the count. As an input-capture unit it copies the running count into the reference register when a chosen edge arrives on the capture pin. Each counter step comes from one of five prescaled clock enables, from one edge of an external clock pin, or from nothing (stopped).

Software uses a small write/read register port with four addresses: control (address 0), reference data (address 1), pending status (address 2) and counter (address 3, read only). Reads are combinational from the address. The block has no streaming data path, so every pin is a plain level or single-cycle strobe and there is no back-pressure. Two interrupt outputs are each pending flag ANDed with its enable bit.

Top module: `tmr8_unit`

## Requirements
- R1: After reset the control, data, status and counter reads are all 00h, and the output pin and both interrupt outputs are low.
- R2: Control bits [2:0] select the count source: codes 0 to 4 step the counter on each cycle where prescale enable bit [code] is high, code 7 stops the counter.
- R3: Code 6 counts rising edges and code 5 counts falling edges of the external clock pin. The pin passes through a two-flop synchroniser, each edge gives exactly one step, and the step lands on the third rising clock edge after the pin changes.
- R4: In interval mode (control bits [4:3] = 00), a step taken while the counter equals the active reference clears the counter, flips the output pin and sets match pending (status bit 1). The period is reference + 1 steps.
- R5: In PWM mode (bits [4:3] = 11), the counter is never cleared by a match and wraps from FFh to 00h. The output is high exactly while the active reference is greater than the counter.
- R6: In capture mode (01 = rising, 10 = falling), the selected synchronised edge on the capture pin loads the counter value into the data register and sets match pending. The captured value is the count read at the cycle the pin changed, plus 2. The counter keeps running and the opposite edge does nothing.
- R7: Overflow pending (status bit 0) is set by any step that takes the counter from FFh to 00h, including an interval match at FFh.
- R8: Writing control with bit 5 set clears the counter on that write. Bit 5 always reads back as 0.
- R9: Status bits clear when software writes 0 to them, and writing 1 leaves them unchanged. The overflow interrupt equals overflow pending AND control bit 6. The match interrupt equals match pending AND control bit 7.
- R10: A write to the data register lands in a buffer that is read back at once. The active reference loads from that buffer only on counter overflow, on an interval match or on a clear-bit write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| presc_en_i | input | 5 | Prescaled clock-enable strobes |
| ext_clk_i | input | 1 | External count pin (asynchronous) |
| cap_i | input | 1 | Capture trigger pin (asynchronous) |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 8 | Register write data |
| bus_rdata_o | output | 8 | Register read data for bus_addr_i |
| tmr_out_o | output | 1 | Toggle or PWM output pin |
| ovf_irq_o | output | 1 | Gated overflow interrupt |
| mtc_irq_o | output | 1 | Gated match/capture interrupt |

## Verification
A register write takes effect at the clock edge that samples it, so a clear or a configuration change is visible at the next falling edge, and each internal step after that adds one count per cycle. Edges on the external and capture pins have a three-edge latency. The bench drives a pin at a falling edge, checks that nothing has changed two edges later, and checks the result after the third edge. The PWM output is combinational from the count and the active reference, so it is sampled at a falling edge n cycles after a clear and compared with reference > n. Pending flags and interrupt outputs are checked at the falling edge right after the step that should set them.

// File: rtl/tmr8_pkg.sv
`timescale 1ns/1ps
package tmr8_pkg;
  localparam int SEL_W = 3;

  typedef enum logic [1:0] {
    MODE_INTERVAL = 2'b00,
    MODE_CAP_RISE = 2'b01,
    MODE_CAP_FALL = 2'b10,
    MODE_PWM      = 2'b11
  } tmr_mode_e;

  localparam logic [SEL_W-1:0] SEL_EXT_FALL = 3'd5;
  localparam logic [SEL_W-1:0] SEL_EXT_RISE = 3'd6;
  localparam logic [SEL_W-1:0] SEL_STOP     = 3'd7;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_DATA = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;
  localparam logic [1:0] ADDR_CNT  = 2'd3;

  localparam int CTRL_CLR_BIT = 5;

  typedef struct packed {
    logic             cap_ie;
    logic             ovf_ie;
    tmr_mode_e        mode;
    logic [SEL_W-1:0] sel;
  } tmr_ctrl_t;
endpackage

// File: rtl/tmr8_edge.sv
`timescale 1ns/1ps
module tmr8_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-1:0], pin_i};
  end

  assign rise_o =  sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall_o = ~sh_q[STAGES-1] &  sh_q[STAGES];

  // R3
  edge_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_o && fall_o));
endmodule

// File: rtl/tmr8_regs.sv
`timescale 1ns/1ps
module tmr8_regs
  import tmr8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [1:0]   addr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] cnt_i,
  input  logic         cap_evt_i,
  input  logic [W-1:0] cap_val_i,
  input  logic         ovf_evt_i,
  input  logic         mtch_evt_i,
  output tmr_ctrl_t    ctrl_o,
  output logic [W-1:0] ref_o,
  output logic         clr_o,
  output logic         pend_ovf_o,
  output logic         pend_mtc_o,
  output logic [W-1:0] rdata_o
);
  logic wr_ctrl, wr_data, wr_stat;
  assign wr_ctrl = wr_i && (addr_i == ADDR_CTRL);
  assign wr_data = wr_i && (addr_i == ADDR_DATA);
  assign wr_stat = wr_i && (addr_i == ADDR_STAT);
  assign clr_o   = wr_ctrl && wdata_i[CTRL_CLR_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_o <= '0;
    end else if (wr_ctrl) begin
      ctrl_o.cap_ie <= wdata_i[7];
      ctrl_o.ovf_ie <= wdata_i[6];
      ctrl_o.mode   <= tmr_mode_e'(wdata_i[4:3]);
      ctrl_o.sel    <= wdata_i[2:0];
    end
  end

  // capture has priority over a software write in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ref_o <= '0;
    else if (cap_evt_i) ref_o <= cap_val_i;
    else if (wr_data)   ref_o <= wdata_i;
  end

  logic mtc_set;
  assign mtc_set = mtch_evt_i || cap_evt_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_ovf_o <= 1'b0;
      pend_mtc_o <= 1'b0;
    end else begin
      pend_ovf_o <= ovf_evt_i || (pend_ovf_o && !(wr_stat && !wdata_i[0]));
      pend_mtc_o <= mtc_set   || (pend_mtc_o && !(wr_stat && !wdata_i[1]));
    end
  end

  always_comb begin
    unique case (addr_i)
      ADDR_CTRL: rdata_o = W'({ctrl_o.cap_ie, ctrl_o.ovf_ie, 1'b0,
                               ctrl_o.mode, ctrl_o.sel});
      ADDR_DATA: rdata_o = ref_o;
      ADDR_STAT: rdata_o = W'({pend_mtc_o, pend_ovf_o});
      default:   rdata_o = cnt_i;
    endcase
  end

  // R9
  mpend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mtc_set |=> pend_mtc_o);
  // R9
  mpend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !wdata_i[1] && !mtc_set) |=> !pend_mtc_o);
  // R7
  opend_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt_i |=> pend_ovf_o);
endmodule

// File: rtl/tmr8_core.sv
`timescale 1ns/1ps
module tmr8_core
  import tmr8_pkg::*;
#(
  parameter int W    = 8,
  parameter int NPRE = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  tmr_ctrl_t       ctrl_i,
  input  logic [W-1:0]    ref_i,
  input  logic            clr_i,
  input  logic [NPRE-1:0] presc_en_i,
  input  logic            ext_rise_i,
  input  logic            ext_fall_i,
  input  logic            cap_rise_i,
  input  logic            cap_fall_i,
  output logic [W-1:0]    cnt_o,
  output logic            out_o,
  output logic            ovf_evt_o,
  output logic            mtch_evt_o,
  output logic            cap_evt_o,
  output logic [W-1:0]    cap_val_o
);
  logic         tick;
  logic [W-1:0] cmp_q;
  logic         tog_q;
  logic         hit;

  always_comb begin
    tick = 1'b0;
    for (int i = 0; i < NPRE; i++) begin
      if (ctrl_i.sel == SEL_W'(i)) tick = presc_en_i[i];
    end
    if (ctrl_i.sel == SEL_EXT_RISE) tick = ext_rise_i;
    if (ctrl_i.sel == SEL_EXT_FALL) tick = ext_fall_i;
    if (ctrl_i.sel == SEL_STOP)     tick = 1'b0;
  end

  assign hit        = (ctrl_i.mode == MODE_INTERVAL) && (cnt_o == cmp_q);
  assign ovf_evt_o  = tick && !clr_i && (cnt_o == {W{1'b1}});
  assign mtch_evt_o = tick && !clr_i && hit;
  assign cap_evt_o  = ((ctrl_i.mode == MODE_CAP_RISE) && cap_rise_i) ||
                      ((ctrl_i.mode == MODE_CAP_FALL) && cap_fall_i);
  assign cap_val_o  = cnt_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else if (tick)  cnt_o <= hit ? '0 : cnt_o + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                              cmp_q <= '0;
    else if (clr_i || ovf_evt_o || mtch_evt_o) cmp_q <= ref_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          tog_q <= 1'b0;
    else if (mtch_evt_o) tog_q <= ~tog_q;
  end

  assign out_o = (ctrl_i.mode == MODE_PWM) ? (cmp_q > cnt_o) : tog_q;

  // R8
  clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (cnt_o == '0));
  // R2
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ctrl_i.sel == SEL_STOP) && !clr_i) |=> $stable(cnt_o));
  // R7
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt_o |=> (cnt_o == '0));
  // R10
  cmp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !ovf_evt_o && !mtch_evt_o) |=> $stable(cmp_q));
endmodule

// File: rtl/tmr8_unit.sv
`timescale 1ns/1ps
module tmr8_unit
  import tmr8_pkg::*;
#(
  parameter int W      = 8,
  parameter int NPRE   = 5,
  parameter int STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPRE-1:0] presc_en_i,
  input  logic            ext_clk_i,
  input  logic            cap_i,
  input  logic            bus_wr_i,
  input  logic [1:0]      bus_addr_i,
  input  logic [W-1:0]    bus_wdata_i,
  output logic [W-1:0]    bus_rdata_o,
  output logic            tmr_out_o,
  output logic            ovf_irq_o,
  output logic            mtc_irq_o
);
  tmr_ctrl_t    ctrl;
  logic [W-1:0] ref_val, cnt, cap_val;
  logic         clr, pend_ovf, pend_mtc;
  logic         ext_rise, ext_fall, cap_rise, cap_fall;
  logic         ovf_evt, mtch_evt, cap_evt;

  tmr8_edge #(.STAGES(STAGES)) u_ext_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(ext_clk_i),
    .rise_o(ext_rise), .fall_o(ext_fall));

  tmr8_edge #(.STAGES(STAGES)) u_cap_sync (
    .clk(clk), .rst_n(rst_n), .pin_i(cap_i),
    .rise_o(cap_rise), .fall_o(cap_fall));

  tmr8_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_i(bus_wr_i), .addr_i(bus_addr_i), .wdata_i(bus_wdata_i),
    .cnt_i(cnt), .cap_evt_i(cap_evt), .cap_val_i(cap_val),
    .ovf_evt_i(ovf_evt), .mtch_evt_i(mtch_evt),
    .ctrl_o(ctrl), .ref_o(ref_val), .clr_o(clr),
    .pend_ovf_o(pend_ovf), .pend_mtc_o(pend_mtc), .rdata_o(bus_rdata_o));

  tmr8_core #(.W(W), .NPRE(NPRE)) u_core (
    .clk(clk), .rst_n(rst_n),
    .ctrl_i(ctrl), .ref_i(ref_val), .clr_i(clr), .presc_en_i(presc_en_i),
    .ext_rise_i(ext_rise), .ext_fall_i(ext_fall),
    .cap_rise_i(cap_rise), .cap_fall_i(cap_fall),
    .cnt_o(cnt), .out_o(tmr_out_o),
    .ovf_evt_o(ovf_evt), .mtch_evt_o(mtch_evt),
    .cap_evt_o(cap_evt), .cap_val_o(cap_val));

  assign ovf_irq_o = pend_ovf && ctrl.ovf_ie;
  assign mtc_irq_o = pend_mtc && ctrl.cap_ie;
endmodule

// File: tb/tmr8_unit_tb.sv
`timescale 1ns/1ps
module tmr8_unit_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] presc = '0;
  logic       ext = 1'b0, cap = 1'b0;
  logic       wr = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       tout, oirq, mirq;
  int         total = 0, fails = 0, cyc = 0;

  always #2 clk = ~clk;

  tmr8_unit u_dut (
    .clk(clk), .rst_n(rst_n), .presc_en_i(presc), .ext_clk_i(ext),
    .cap_i(cap), .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .tmr_out_o(tout), .ovf_irq_o(oirq),
    .mtc_irq_o(mirq));

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      total++; fails++;
      $display("FAIL watchdog act=%0d exp=<100000", cyc);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  function automatic int exp_pwm(input int d, input int c);
    return (d > c) ? 1 : 0;
  endfunction
  function automatic int exp_cap(input int c);
    return (c + 2) % 256;
  endfunction
  function automatic logic [7:0] ctrl_rb(input logic [7:0] w);
    return w & 8'hDF;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic bw(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic peek(input logic [1:0] a, output int v);
    addr = a; #0.2; v = int'(rdata);
  endtask

  int v, c, n, d, k, sel, base, m;

  initial begin
    void'($urandom(32'd51977));
    step(4); rst_n = 1'b1; step(1);

    // R1 reset state
    peek(2'd0, v); chk("R1 ctrl", v, 0);
    peek(2'd1, v); chk("R1 data", v, 0);
    peek(2'd2, v); chk("R1 stat", v, 0);
    peek(2'd3, v); chk("R1 cnt", v, 0);
    chk("R1 pins", {tout, oirq, mirq}, 0);

    // R2 internal source select, R8 clear readback
    for (int i = 0; i < 8; i++) begin
      k = $urandom % 5;
      sel = (i % 3 == 0) ? k : (i == 7 ? 7 : $urandom % 5);
      presc = 5'(1 << k);
      if (i == 7) presc = 5'h1F;
      bw(2'd0, 8'h38 | 8'(sel));
      n = $urandom % 40 + 1;
      step(n);
      peek(2'd3, v); chk("R2 count", v, (sel == k && i != 7) ? n : 0);
      peek(2'd0, v); chk("R8 readback", v, ctrl_rb(8'h38 | 8'(sel)));
    end

    // R3 external rising edges
    presc = '0;
    bw(2'd0, 8'h3E);
    m = $urandom % 6 + 2;
    for (int i = 0; i < m; i++) begin ext = 1'b1; step(4); ext = 1'b0; step(4); end
    peek(2'd3, v); chk("R3 rise count", v, m);
    ext = 1'b1; step(2); peek(2'd3, v); chk("R3 latency early", v, m);
    step(1); peek(2'd3, v); chk("R3 latency due", v, m + 1);
    ext = 1'b0; step(4);
    // R3 falling edges
    bw(2'd0, 8'h3D);
    ext = 1'b1; step(4); peek(2'd3, v); chk("R3 rise ignored", v, 0);
    ext = 1'b0; step(4); peek(2'd3, v); chk("R3 fall count", v, 1);

    // R4 interval mode
    presc = 5'h01;
    for (int i = 0; i < 3; i++) begin
      d = $urandom % 29 + 2;
      bw(2'd0, 8'h27);
      bw(2'd1, 8'(d));
      bw(2'd2, 8'h00);
      base = int'(tout);
      bw(2'd0, 8'hA0);
      step(d);
      peek(2'd3, v); chk("R4 cnt at ref", v, d);
      chk("R4 out held", int'(tout), base);
      step(1);
      peek(2'd3, v); chk("R4 cnt cleared", v, 0);
      chk("R4 out toggled", int'(tout), 1 - base);
      chk("R9 match irq", int'(mirq), 1);
      step(d + 1);
      chk("R4 second toggle", int'(tout), base);
    end

    // R9 pending clear semantics
    bw(2'd0, 8'h87);
    peek(2'd2, v); chk("R9 stat before", v, 2);
    bw(2'd2, 8'h03); peek(2'd2, v); chk("R9 write1 no effect", v, 2);
    bw(2'd2, 8'h00); peek(2'd2, v); chk("R9 write0 clears", v, 0);
    chk("R9 irq off", int'(mirq), 0);

    // R7 overflow in PWM
    bw(2'd0, 8'h3F); bw(2'd1, 8'h00); bw(2'd2, 8'h00);
    bw(2'd0, 8'h78);
    step(255); peek(2'd2, v); chk("R7 no ovf yet", v, 0);
    step(1); peek(2'd3, v); chk("R7 wrap", v, 0);
    peek(2'd2, v); chk("R7 ovf pend", v, 1);
    chk("R9 ovf irq", int'(oirq), 1);
    // R7 interval with reference FF, R9 gating off
    bw(2'd0, 8'h27); bw(2'd1, 8'hFF); bw(2'd2, 8'h00);
    bw(2'd0, 8'h20);
    step(256); peek(2'd2, v); chk("R7 interval FF", v, 3);
    chk("R9 gated irqs", {oirq, mirq}, 0);

    // R5 PWM duty
    for (int i = 0; i < 8; i++) begin
      d = (i == 0) ? 0 : (i == 1 ? 255 : $urandom % 256);
      n = (i == 1) ? 254 : $urandom % 256;
      bw(2'd0, 8'h3F); bw(2'd1, 8'(d));
      bw(2'd0, 8'h38);
      step(n);
      chk("R5 pwm level", int'(tout), exp_pwm(d, n));
      if (i < 2) begin
        step(1); chk("R5 pwm next", int'(tout), exp_pwm(d, n + 1));
        n = n + 1;
      end
      step(256);
      peek(2'd3, v); chk("R5 wrap same count", v, n);
      chk("R5 level after wrap", int'(tout), exp_pwm(d, n));
    end

    // R10 staged reference
    bw(2'd0, 8'h3F); bw(2'd1, 8'd100); bw(2'd0, 8'h38);
    step(50); chk("R10 old ref", int'(tout), exp_pwm(100, 50));
    bw(2'd1, 8'd20);
    peek(2'd1, v); chk("R10 buffer readback", v, 20);
    chk("R10 still old ref", int'(tout), exp_pwm(100, 52));
    step(204); peek(2'd3, v); chk("R10 wrapped", v, 0);
    step(52); chk("R10 new ref", int'(tout), exp_pwm(20, 52));

    // R6 capture rising
    bw(2'd0, 8'h3F); bw(2'd2, 8'h00);
    bw(2'd0, 8'hA8);
    step($urandom % 50 + 5);
    peek(2'd3, c); cap = 1'b1;
    step(2); peek(2'd2, v); chk("R6 not yet", v, 0);
    step(1);
    peek(2'd1, v); chk("R6 rise value", v, exp_cap(c));
    peek(2'd2, v); chk("R6 pend", v, 2);
    peek(2'd3, v); chk("R6 count runs", v, c + 3);
    cap = 1'b0; step(4);
    peek(2'd1, v); chk("R6 fall ignored", v, exp_cap(c));
    // R6 capture falling
    bw(2'd0, 8'h30);
    step($urandom % 30 + 3);
    cap = 1'b1; step(4);
    peek(2'd1, v); chk("R6 rise ignored", v, exp_cap(c));
    peek(2'd3, c); cap = 1'b0;
    step(3);
    peek(2'd1, v); chk("R6 fall value", v, exp_cap(c));

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule